// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block is the sequencing core of a microprogrammed control unit. It keeps a 6-bit control address register (CAR), a 64-word control store whose contents are fixed inside the design, a control buffer register (CBR) that holds the word at the current CAR, and a one-entry return register. In every clock, the word in the CBR drives a decoded control-signal vector. In the same clock, the CBR, the ALU flags, a register sign bit, the internal status bits and the instruction opcode select the next microaddress. At the clock edge, CAR takes that address and the CBR takes the stored word at it.

Each 16-bit microword is one of two kinds, selected by bit 15. A control word (bit 15 = 0) drives control lines. It then continues sequentially or jumps to a routine whose address is formed from the opcode. A branch word (bit 15 = 1) drives no control lines. It jumps, branches on a condition, calls a subroutine or returns from one. The ALU field of a control word has two levels: a group bit picks arithmetic or shift, and three bits pick one of eight operations in that group. The decoder expands these four bits into sixteen one-hot lines.

Top module: `useq_core`

## Requirements
- R1: A synchronous active-high reset sets CAR to 0, sets the return register to 0, and loads the CBR with 16'h8000 (unconditional branch to address 0), so `ctrl_o` is 0. The cycle after release shows CAR 0 again with the stored word at address 0 in the CBR.
- R2: A control word with bit 14 = 0 moves CAR to CAR+1 modulo 64, so address 63 wraps to 0.
- R3: A control word with bit 14 = 1 loads CAR with {opcode_i, 2'b00}, which gives each opcode a four-word routine.
- R4: A branch word's condition field is bits [14:12] and its target is bits [5:0]. Condition 0 always loads the target.
- R5: Conditions 1, 2 and 3 test `flag_zero_i`, `flag_carry_i` and `reg_sign_i`. The branch loads the target when the tested input is 1 and moves to CAR+1 when it is 0.
- R6: Condition 4 tests `status_i[k]`, where k is branch-word bits [11:10]. The branch loads the target when that bit is 1 and moves to CAR+1 when it is 0.
- R7: Condition 5 (call) loads the target and stores CAR+1 in the return register. Condition 6 (return) loads CAR from the return register.
- R8: Condition 7 is reserved and acts as no branch: CAR moves to CAR+1.
- R9: For a control word, `ctrl_o[10+8*b13+b[12:10]]` is the only set bit of `ctrl_o[25:10]`, and `ctrl_o[9:0]` equals word bits [9:0]. For a branch word, `ctrl_o` is all zero.
- R10: The store holds the following words, and every other address holds a branch-always to 0.
  - Control words, written as (address: next-address mode, ALU line, misc bits): 0: seq, arith0, 001h. 1: map, arith0, 002h. 4: seq, arith1, 004h. 9: seq, arith2, 008h. 13: seq, arith3, 010h. 17: seq, shift1, 020h. 21: seq, shift7, 040h. 25: seq, arith5, 080h. 29: seq, arith7, 100h. 30: seq, shift4, 200h. 40: seq, shift0, 201h. 63: seq, shift6, 155h.
  - Branch words, written as (address: condition, target): 8: zero, 10. 12: carry, 14. 16: sign, 18. 20: status with k=2, 22. 24: call, 40. 28: reserved, 30. 41: return. 60: always, 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Opcode from the instruction register |
| flag_zero_i | input | 1 | ALU zero flag |
| flag_carry_i | input | 1 | ALU carry flag |
| reg_sign_i | input | 1 | Sign bit of the selected register |
| status_i | input | 4 | Status bits held in the control unit |
| ctrl_o | output | 26 | Decoded control vector: [25:10] ALU lines, [9:0] misc lines |
| car_o | output | 6 | Current control address |

## Verification
A branch word silences the control lines in the very cycle that its condition logic chooses the next address. A call also writes the return register in that cycle. Every condition input changes randomly on every cycle, including the cycles when a call, a return or a conditional branch is in the CBR. Judgement is cycle by cycle: the CAR sequence and the control vector must match a model built from the field encodings. An inactive condition input must change neither the branch decision nor the saved return address.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int AW        = 6;
    localparam int DEPTH     = 1 << AW;
    localparam int OPW       = 4;
    localparam int ROUTW     = AW - OPW;
    localparam int OPSELW    = 3;
    localparam int ALUW      = OPSELW + 1;
    localparam int NALU      = 1 << ALUW;
    localparam int MISCW     = 10;
    localparam int CW        = NALU + MISCW;
    localparam int NSTAT     = 4;
    localparam int SELW      = $clog2(NSTAT);
    localparam int WW        = 16;
    localparam int PADW      = WW - 1 - 3 - SELW - AW;

    typedef logic [AW-1:0] uaddr_t;

    typedef enum logic [2:0] {
        C_ALWAYS = 3'd0,
        C_ZERO   = 3'd1,
        C_CARRY  = 3'd2,
        C_SIGN   = 3'd3,
        C_STAT   = 3'd4,
        C_CALL   = 3'd5,
        C_RET    = 3'd6,
        C_RSVD   = 3'd7
    } cond_e;

    typedef struct packed {
        logic              shift;
        logic [OPSELW-1:0] op;
    } alu_sel_t;

    typedef struct packed {
        logic             fmt;
        logic             map;
        alu_sel_t         alu;
        logic [MISCW-1:0] misc;
    } ctl_word_t;

    typedef struct packed {
        logic            fmt;
        cond_e           cond;
        logic [SELW-1:0] stat_sel;
        logic [PADW-1:0] pad;
        uaddr_t          target;
    } br_word_t;

    typedef logic [WW-1:0] uword_t;

    function automatic uword_t mk_ctl(input logic m, input logic s,
                                      input logic [OPSELW-1:0] op,
                                      input logic [MISCW-1:0] misc);
        ctl_word_t w;
        w.fmt       = 1'b0;
        w.map       = m;
        w.alu.shift = s;
        w.alu.op    = op;
        w.misc      = misc;
        return uword_t'(w);
    endfunction

    function automatic uword_t mk_br(input cond_e c, input logic [SELW-1:0] sel,
                                     input uaddr_t tgt);
        br_word_t w;
        w.fmt      = 1'b1;
        w.cond     = c;
        w.stat_sel = sel;
        w.pad      = '0;
        w.target   = tgt;
        return uword_t'(w);
    endfunction

    localparam uword_t IDLE_WORD = 16'h8000;

    // Fixed microprogram: fetch at 0, opcode dispatch at 1, routines at 4*opcode.
    function automatic uword_t program_word(input uaddr_t a);
        uword_t w;
        case (a)
            6'd0:  w = mk_ctl(1'b0, 1'b0, 3'd0, 10'h001);
            6'd1:  w = mk_ctl(1'b1, 1'b0, 3'd0, 10'h002);
            6'd4:  w = mk_ctl(1'b0, 1'b0, 3'd1, 10'h004);
            6'd8:  w = mk_br(C_ZERO,  2'd0, 6'd10);
            6'd9:  w = mk_ctl(1'b0, 1'b0, 3'd2, 10'h008);
            6'd12: w = mk_br(C_CARRY, 2'd0, 6'd14);
            6'd13: w = mk_ctl(1'b0, 1'b0, 3'd3, 10'h010);
            6'd16: w = mk_br(C_SIGN,  2'd0, 6'd18);
            6'd17: w = mk_ctl(1'b0, 1'b1, 3'd1, 10'h020);
            6'd20: w = mk_br(C_STAT,  2'd2, 6'd22);
            6'd21: w = mk_ctl(1'b0, 1'b1, 3'd7, 10'h040);
            6'd24: w = mk_br(C_CALL,  2'd0, 6'd40);
            6'd25: w = mk_ctl(1'b0, 1'b0, 3'd5, 10'h080);
            6'd28: w = mk_br(C_RSVD,  2'd0, 6'd30);
            6'd29: w = mk_ctl(1'b0, 1'b0, 3'd7, 10'h100);
            6'd30: w = mk_ctl(1'b0, 1'b1, 3'd4, 10'h200);
            6'd40: w = mk_ctl(1'b0, 1'b1, 3'd0, 10'h201);
            6'd41: w = mk_br(C_RET,   2'd0, 6'd0);
            6'd60: w = mk_br(C_ALWAYS, 2'd0, 6'd63);
            6'd63: w = mk_ctl(1'b0, 1'b1, 3'd6, 10'h155);
            default: w = IDLE_WORD;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  uaddr_t addr_i,
    output uword_t word_o
);
    uword_t mem [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        assign mem[a] = program_word(uaddr_t'(a));
    end

    assign word_o = mem[addr_i];
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  uaddr_t           car_i,
    input  uword_t           cbr_i,
    input  logic [OPW-1:0]   opcode_i,
    input  logic             zero_i,
    input  logic             carry_i,
    input  logic             sign_i,
    input  logic [NSTAT-1:0] status_i,
    input  uaddr_t           ret_i,
    output uaddr_t           next_o,
    output logic             ret_we_o,
    output uaddr_t           ret_d_o
);
    ctl_word_t cw;
    br_word_t  bw;
    uaddr_t    seq_addr;
    uaddr_t    map_addr;
    logic      cond_hit;

    assign cw       = ctl_word_t'(cbr_i);
    assign bw       = br_word_t'(cbr_i);
    assign seq_addr = car_i + uaddr_t'(1);
    assign map_addr = {opcode_i, {ROUTW{1'b0}}};
    assign ret_d_o  = seq_addr;

    always_comb begin
        cond_hit = 1'b0;
        case (bw.cond)
            C_ZERO:  cond_hit = zero_i;
            C_CARRY: cond_hit = carry_i;
            C_SIGN:  cond_hit = sign_i;
            C_STAT:  cond_hit = status_i[bw.stat_sel];
            default: cond_hit = 1'b0;
        endcase
    end

    always_comb begin
        ret_we_o = 1'b0;
        if (!cw.fmt) begin
            next_o = cw.map ? map_addr : seq_addr;
        end else begin
            case (bw.cond)
                C_ALWAYS: next_o = bw.target;
                C_CALL: begin
                    next_o   = bw.target;
                    ret_we_o = 1'b1;
                end
                C_RET:   next_o = ret_i;
                C_RSVD:  next_o = seq_addr;
                default: next_o = cond_hit ? bw.target : seq_addr;
            endcase
        end
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  uword_t        cbr_i,
    output logic [CW-1:0] ctrl_o
);
    ctl_word_t       cw;
    logic [NALU-1:0] alu_lines;

    assign cw = ctl_word_t'(cbr_i);

    for (genvar i = 0; i < NALU; i++) begin : g_alu
        assign alu_lines[i] = ~cw.fmt & (cw.alu == alu_sel_t'(i));
    end

    assign ctrl_o = {alu_lines, cw.fmt ? {MISCW{1'b0}} : cw.misc};
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [OPW-1:0]         opcode_i,
    input  logic                   flag_zero_i,
    input  logic                   flag_carry_i,
    input  logic                   reg_sign_i,
    input  logic [NSTAT-1:0]       status_i,
    output logic [CW-1:0]          ctrl_o,
    output logic [AW-1:0]          car_o
);
    uaddr_t car_q;
    uword_t cbr_q;
    uaddr_t ret_q;
    uaddr_t car_d;
    uword_t rom_word;
    logic   ret_we;
    uaddr_t ret_d;

    useq_next u_next (
        .car_i    (car_q),
        .cbr_i    (cbr_q),
        .opcode_i (opcode_i),
        .zero_i   (flag_zero_i),
        .carry_i  (flag_carry_i),
        .sign_i   (reg_sign_i),
        .status_i (status_i),
        .ret_i    (ret_q),
        .next_o   (car_d),
        .ret_we_o (ret_we),
        .ret_d_o  (ret_d)
    );

    useq_store u_store (
        .addr_i (car_d),
        .word_o (rom_word)
    );

    useq_decode u_decode (
        .cbr_i  (cbr_q),
        .ctrl_o (ctrl_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= '0;
            cbr_q <= IDLE_WORD;
            ret_q <= '0;
        end else begin
            car_q <= car_d;
            cbr_q <= rom_word;
            if (ret_we) ret_q <= ret_d;
        end
    end

    assign car_o = car_q;
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk
    import useq_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input uaddr_t         car,
    input uword_t         cbr,
    input uaddr_t         ret,
    input logic [OPW-1:0] opcode,
    input logic           zero,
    input logic [CW-1:0]  ctrl
);
    logic       is_br;
    logic [2:0] cnd;
    uaddr_t     tgt;

    assign is_br = cbr[15];
    assign cnd   = cbr[14:12];
    assign tgt   = cbr[5:0];

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        $fell(rst) |-> (car == '0 && ctrl == '0));

    p_seq_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_br && !cbr[14]) |=> car == ($past(car) + 6'd1));

    p_map_r3: assert property (@(posedge clk) disable iff (rst)
        (!is_br && cbr[14]) |=> car == {$past(opcode), 2'b00});

    p_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (is_br && cnd == 3'd0) |=> car == $past(tgt));

    p_zero_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (is_br && cnd == 3'd1 && zero) |=> car == $past(tgt));

    p_zero_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (is_br && cnd == 3'd1 && !zero) |=> car == ($past(car) + 6'd1));

    p_call_save_r7: assert property (@(posedge clk) disable iff (rst)
        (is_br && cnd == 3'd5) |=> (ret == ($past(car) + 6'd1) && car == $past(tgt)));

    p_return_r7: assert property (@(posedge clk) disable iff (rst)
        (is_br && cnd == 3'd6) |=> car == $past(ret));

    p_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
        (is_br && cnd == 3'd7) |=> car == ($past(car) + 6'd1));

    p_alu_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        !is_br |-> $onehot(ctrl[CW-1:MISCW]));

    p_branch_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        is_br |-> ctrl == '0);
endmodule

bind useq_core useq_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .car    (car_q),
    .cbr    (cbr_q),
    .ret    (ret_q),
    .opcode (opcode_i),
    .zero   (flag_zero_i),
    .ctrl   (ctrl_o)
);

// File: tb/useq_core_bench.sv
`timescale 1ns/1ps
module useq_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode_i = '0;
    logic        flag_zero_i = 1'b0;
    logic        flag_carry_i = 1'b0;
    logic        reg_sign_i = 1'b0;
    logic [3:0]  status_i = '0;
    logic [25:0] ctrl_o;
    logic [5:0]  car_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [5:0]  exp_car;
    logic [15:0] exp_cbr;
    logic [5:0]  exp_ret;
    string       last_tag = "R1";

    always #2 clk = ~clk;

    useq_core u_useq_core (
        .clk          (clk),
        .rst          (rst),
        .opcode_i     (opcode_i),
        .flag_zero_i  (flag_zero_i),
        .flag_carry_i (flag_carry_i),
        .reg_sign_i   (reg_sign_i),
        .status_i     (status_i),
        .ctrl_o       (ctrl_o),
        .car_o        (car_o)
    );

    // R10 program contents, written from the requirement list.
    function automatic logic [15:0] ctl(input bit m, input bit s, input int op, input int misc);
        return {1'b0, m, s, 3'(op), 10'(misc)};
    endfunction
    function automatic logic [15:0] br(input int c, input int sel, input int t);
        return {1'b1, 3'(c), 2'(sel), 4'b0, 6'(t)};
    endfunction
    function automatic logic [15:0] prog(input logic [5:0] a);
        case (a)
            6'd0:  return ctl(0, 0, 0, 'h001);
            6'd1:  return ctl(1, 0, 0, 'h002);
            6'd4:  return ctl(0, 0, 1, 'h004);
            6'd8:  return br(1, 0, 10);
            6'd9:  return ctl(0, 0, 2, 'h008);
            6'd12: return br(2, 0, 14);
            6'd13: return ctl(0, 0, 3, 'h010);
            6'd16: return br(3, 0, 18);
            6'd17: return ctl(0, 1, 1, 'h020);
            6'd20: return br(4, 2, 22);
            6'd21: return ctl(0, 1, 7, 'h040);
            6'd24: return br(5, 0, 40);
            6'd25: return ctl(0, 0, 5, 'h080);
            6'd28: return br(7, 0, 30);
            6'd29: return ctl(0, 0, 7, 'h100);
            6'd30: return ctl(0, 1, 4, 'h200);
            6'd40: return ctl(0, 1, 0, 'h201);
            6'd41: return br(6, 0, 0);
            6'd60: return br(0, 0, 63);
            6'd63: return ctl(0, 1, 6, 'h155);
            default: return 16'h8000;
        endcase
    endfunction

    // R9 expected control vector
    function automatic logic [25:0] ctrl_of(input logic [15:0] w);
        if (w[15]) return '0;
        return (26'd1 << (10 + int'(w[13:10]))) | {16'b0, w[9:0]};
    endfunction

    task automatic model_reset();
        exp_car  = '0;
        exp_cbr  = 16'h8000;
        exp_ret  = '0;
        last_tag = "R1";
    endtask

    task automatic model_step();
        logic [5:0] nxt;
        logic [5:0] seq;
        logic       hit;
        seq = exp_car + 6'd1;
        if (!exp_cbr[15]) begin
            if (exp_cbr[14]) begin nxt = {opcode_i, 2'b00}; last_tag = "R3"; end
            else begin nxt = seq; last_tag = "R2"; end
        end else begin
            hit = 1'b0;
            case (exp_cbr[14:12])
                3'd0: begin nxt = exp_cbr[5:0]; last_tag = "R4"; end
                3'd1, 3'd2, 3'd3: begin
                    hit = (exp_cbr[14:12] == 3'd1) ? flag_zero_i :
                          (exp_cbr[14:12] == 3'd2) ? flag_carry_i : reg_sign_i;
                    nxt = hit ? exp_cbr[5:0] : seq; last_tag = "R5";
                end
                3'd4: begin
                    hit = status_i[exp_cbr[11:10]];
                    nxt = hit ? exp_cbr[5:0] : seq; last_tag = "R6";
                end
                3'd5: begin exp_ret = seq; nxt = exp_cbr[5:0]; last_tag = "R7"; end
                3'd6: begin nxt = exp_ret; last_tag = "R7"; end
                default: begin nxt = seq; last_tag = "R8"; end
            endcase
        end
        exp_car = nxt;
        exp_cbr = prog(nxt);
    endtask

    task automatic drive(input logic [3:0] op, input logic z, input logic c,
                         input logic s, input logic [3:0] st);
        opcode_i = op; flag_zero_i = z; flag_carry_i = c;
        reg_sign_i = s; status_i = st;
        model_step();
    endtask

    task automatic check_outputs();
        checks++;
        if (car_o !== exp_car) begin
            failures++;
            $display("FAIL %s (R10 trace) car_o actual=%0d expected=%0d", last_tag, car_o, exp_car);
        end
        checks++;
        if (ctrl_o !== ctrl_of(exp_cbr)) begin
            failures++;
            $display("FAIL R9 ctrl_o actual=%h expected=%h at car %0d", ctrl_o, ctrl_of(exp_cbr), exp_car);
        end
    endtask

    task automatic check_reset();
        checks++;
        if (car_o !== 6'd0 || ctrl_o !== 26'd0) begin
            failures++;
            $display("FAIL R1 reset car=%0d ctrl=%h expected car=0 ctrl=0", car_o, ctrl_o);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset();
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240613));
        model_reset();
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;
        drive('0, 0, 0, 0, '0);
        // Directed: every opcode with all condition inputs low, then all high.
        for (int op = 0; op < 16; op++) begin
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 12; k++) begin
                    @(negedge clk);
                    check_outputs();
                    drive(4'(op), p[0], p[0], p[0], {4{p[0]}});
                end
            end
        end
        // Directed: status select picks bit 2 only (R6).
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check_outputs();
            drive(4'd5, 0, 0, 0, 4'b1011);
        end
        do_reset();
        drive('0, 0, 0, 0, '0);
        // Random: opcodes and all condition inputs change every cycle.
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            check_outputs();
            drive(4'($urandom_range(15)), 1'($urandom), 1'($urandom),
                  1'($urandom), 4'($urandom));
            if (k == 2000) begin
                @(negedge clk);
                check_outputs();
                do_reset();
                drive('0, 0, 0, 0, '0);
            end
        end
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(100000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule